// File: doc/BRIEF.md
# Multi-channel on/off delay filter

This block conditions a bank of boolean condition bits. Each channel sees its raw bit and its own configuration: an on-delay, an off-delay and a two-bit read-error option. From these it produces a debounced output bit, a bad-status flag and an elapsed-time counter. All timing is counted in scan ticks: a tick-enable input marks the clock cycles on which the filter advances, and on any other cycle nothing in the block changes.

The on-delay and off-delay are measured as "more than D consecutive ticks". A delay of zero therefore makes the output follow the input on the next tick. The elapsed counter has two meanings, chosen by whether the channel's off-delay is zero:
- With a zero off-delay, it counts ticks since the input rose.
- With a non-zero off-delay, it counts ticks since the input fell.

A per-channel error flag overrides the filter: the output is forced to 0, forced to 1 or held, and the status is marked bad. A global abort mode turns any error on any channel into a freeze of the whole bank for that tick. Channel disabling is left to downstream logic.

Top module: `dfilt_bank`

## Requirements
- R1: After reset, every output bit, every status flag and every elapsed counter is 0.
- R2: On a cycle with the tick enable low, no output, status or elapsed counter changes, whatever the other inputs do.
- R3: A channel whose output is 0 raises it on the tick that completes more than on-delay consecutive ticks with the input at 1. A 0 before then restarts the count.
- R4: A channel whose output is 1 drops it on the tick that completes more than off-delay consecutive ticks with the input at 0. With off-delay 0 it drops on the first such tick. A 1 before then restarts the count.
- R5: With off-delay 0, the elapsed counter becomes 1 on the tick where the input is first seen high. It then increments on every tick with the input high, holds while the input is low, and becomes 0 on the tick where the output falls.
- R6: With a non-zero off-delay, the elapsed counter becomes 1 on the tick where the input is first seen low. It then increments on every tick with the input low, holds while the input is high, and becomes 0 on the tick where the output rises.
- R7: On a tick with the channel's error flag set and no freeze, the status flag becomes 1 and the output takes the value given by the option: 0 forces 0, 1 forces 1, 2 or 3 holds the last value. The elapsed counter holds. The status returns to 0 on the first tick without error.
- R8: With abort mode set, a tick on which any channel's error flag is high leaves every output, status and elapsed counter of every channel unchanged.
- R9: The elapsed counter saturates at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Scan tick enable; filter advances only when high |
| abort_mode | input | 1 | Freeze the whole bank on any read error |
| cond_in | input | NCH | Raw condition bit per channel |
| rd_err | input | NCH | Read-error flag per channel |
| on_dly | input | NCH*DW | On-delay per channel, channel i at bits [i*DW +: DW] |
| off_dly | input | NCH*DW | Off-delay per channel, same packing |
| err_opt | input | 2*NCH | Read-error option per channel, channel i at bits [2i +: 2] |
| filt_out | output | NCH | Filtered output per channel |
| stat_bad | output | NCH | Bad-status flag per channel |
| elapsed | output | NCH*DW | Elapsed counter per channel, same packing as the delays |

## Verification
The assertions assume that the delay, option and abort configuration changes only while the block is idle or in reset, and never between the ticks of an ongoing delay. The stimulus therefore loads every configuration once, before reset is released. The assertions also take inputs as sampled at the clock edge. The bench changes inputs only on the falling edge, and the tick enable is the sole control that gates updates. Error flags are raised only for whole ticks, and abort mode is toggled only between ticks.

// File: rtl/dfilt_pkg.sv
package dfilt_pkg;
  typedef enum logic [1:0] {
    ERR_FORCE0 = 2'd0,
    ERR_FORCE1 = 2'd1,
    ERR_HOLD   = 2'd2,
    ERR_HOLD_B = 2'd3
  } err_opt_e;

  // output chosen while a channel is in read error
  function automatic logic err_value(input logic [1:0] opt, input logic last);
    case (err_opt_e'(opt))
      ERR_FORCE0: err_value = 1'b0;
      ERR_FORCE1: err_value = 1'b1;
      default:    err_value = last;
    endcase
  endfunction
endpackage

// File: rtl/dfilt_freeze.sv
module dfilt_freeze #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           abort_mode,
  input  logic [NCH-1:0] rd_err,
  output logic           frz
);
  logic any_err;
  always_comb any_err = |rd_err;
  always_comb frz = abort_mode & any_err;

  // R8
  frz_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!abort_mode || rd_err == '0) |-> !frz);
endmodule

// File: rtl/dfilt_chan.sv
module dfilt_chan #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          frz,
  input  logic          cond,
  input  logic          err,
  input  logic [DW-1:0] on_dly,
  input  logic [DW-1:0] off_dly,
  input  logic [1:0]    opt,
  output logic          out,
  output logic          bad,
  output logic [DW-1:0] elap
);
  import dfilt_pkg::*;

  localparam logic [DW-1:0] CNT_MAX = {DW{1'b1}};
  localparam logic [DW-1:0] CNT_ONE = DW'(1);

  function automatic logic [DW-1:0] sat_inc(input logic [DW-1:0] v);
    sat_inc = (v == CNT_MAX) ? v : v + CNT_ONE;
  endfunction

  function automatic logic [DW-1:0] elap_step(
    input logic off_zero, input logic in_up, input logic in_dn,
    input logic in_now, input logic rise, input logic fall,
    input logic [DW-1:0] cur);
    if (off_zero) begin
      if (fall)        elap_step = '0;
      else if (in_up)  elap_step = CNT_ONE;
      else if (in_now) elap_step = sat_inc(cur);
      else             elap_step = cur;
    end else begin
      if (rise)        elap_step = '0;
      else if (in_dn)  elap_step = CNT_ONE;
      else if (!in_now) elap_step = sat_inc(cur);
      else             elap_step = cur;
    end
  endfunction

  logic          out_q, bad_q, prev_q;
  logic [DW-1:0] run_q, elap_q;

  // named internal events
  logic          adv, err_tick, run_hit, filt_nxt, rise_ev, fall_ev, in_up, in_dn, off_zero;
  logic [DW-1:0] run_nxt, elap_nxt;

  always_comb begin
    adv      = tick & ~frz;
    err_tick = adv & err;
    off_zero = (off_dly == '0);
    in_up    = cond & ~prev_q;
    in_dn    = ~cond & prev_q;
    run_hit  = run_q >= (out_q ? off_dly : on_dly);
    filt_nxt = (cond != out_q && run_hit) ? cond : out_q;
    run_nxt  = (cond == out_q || run_hit) ? '0 : sat_inc(run_q);
    rise_ev  = ~out_q & filt_nxt;
    fall_ev  = out_q & ~filt_nxt;
    elap_nxt = elap_step(off_zero, in_up, in_dn, cond, rise_ev, fall_ev, elap_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      bad_q  <= 1'b0;
      prev_q <= 1'b0;
      run_q  <= '0;
      elap_q <= '0;
    end else if (err_tick) begin
      out_q <= err_value(opt, out_q);
      bad_q <= 1'b1;
      run_q <= '0;
    end else if (adv) begin
      out_q  <= filt_nxt;
      bad_q  <= 1'b0;
      prev_q <= cond;
      run_q  <= run_nxt;
      elap_q <= elap_nxt;
    end
  end

  assign out  = out_q;
  assign bad  = bad_q;
  assign elap = elap_q;

  // R2
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(out_q) && $stable(bad_q) && $stable(elap_q));
  // R8
  frz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frz |=> $stable(out_q) && $stable(bad_q) && $stable(elap_q));
  // R3
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> $past(cond) || $past(err));
  // R7
  err_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !frz && err) |=> bad_q && $stable(elap_q));
  // R7
  force0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !frz && err && opt == 2'd0) |=> !out_q);
  // R9
  sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elap_q == CNT_MAX) |=> (elap_q == CNT_MAX || elap_q <= CNT_ONE));
endmodule

// File: rtl/dfilt_bank.sv
module dfilt_bank #(
  parameter int NCH = 4,
  parameter int DW  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             abort_mode,
  input  logic [NCH-1:0]   cond_in,
  input  logic [NCH-1:0]   rd_err,
  input  logic [NCH*DW-1:0] on_dly,
  input  logic [NCH*DW-1:0] off_dly,
  input  logic [2*NCH-1:0] err_opt,
  output logic [NCH-1:0]   filt_out,
  output logic [NCH-1:0]   stat_bad,
  output logic [NCH*DW-1:0] elapsed
);
  logic frz;

  dfilt_freeze #(.NCH(NCH)) u_frz (
    .clk(clk), .rst_n(rst_n), .abort_mode(abort_mode), .rd_err(rd_err), .frz(frz)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dfilt_chan #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .frz(frz),
      .cond(cond_in[i]), .err(rd_err[i]),
      .on_dly(on_dly[i*DW +: DW]), .off_dly(off_dly[i*DW +: DW]),
      .opt(err_opt[2*i +: 2]),
      .out(filt_out[i]), .bad(stat_bad[i]), .elap(elapsed[i*DW +: DW])
    );
  end
endmodule

// File: tb/dfilt_bank_test.sv
module dfilt_bank_test;
  localparam int NCH = 4;
  localparam int DW = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, abort_mode = 1'b0;
  logic [NCH-1:0] cond_in = '0, rd_err = '0;
  logic [NCH*DW-1:0] on_dly, off_dly;
  logic [2*NCH-1:0] err_opt;
  logic [NCH-1:0] filt_out, stat_bad;
  logic [NCH*DW-1:0] elapsed;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dfilt_bank #(.NCH(NCH), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .abort_mode(abort_mode),
    .cond_in(cond_in), .rd_err(rd_err), .on_dly(on_dly), .off_dly(off_dly),
    .err_opt(err_opt), .filt_out(filt_out), .stat_bad(stat_bad), .elapsed(elapsed)
  );

  // {cond0, err0, exp out0, exp bad0, exp elapsed0[7:0]}; ch0: on=2, off=0, opt=force0
  localparam logic [11:0] TBL [12] = '{
    {4'b1000, 8'd1}, {4'b1000, 8'd2}, {4'b0000, 8'd2}, {4'b1000, 8'd1},
    {4'b1000, 8'd2}, {4'b1010, 8'd3}, {4'b1010, 8'd4}, {4'b0000, 8'd0},
    {4'b0000, 8'd0}, {4'b1101, 8'd0}, {4'b1000, 8'd1}, {4'b1101, 8'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] el(input int ch);
    return 32'(elapsed[ch*DW +: DW]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    on_dly  = {16'd0, 16'd0, 16'd0, 16'd2};
    off_dly = {16'd0, 16'd0, 16'd3, 16'd0};
    err_opt = {2'd2, 2'd1, 2'd0, 2'd0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 out", 32'(filt_out), 0);
    chk("R1 bad", 32'(stat_bad), 0);
    chk("R1 elapsed", 32'(elapsed), 0);

    // table walk on channel 0: R3, R4, R5, R7
    tick = 1'b1;
    for (int k = 0; k < 12; k++) begin
      cond_in = {3'b000, TBL[k][11]};
      rd_err  = {3'b000, TBL[k][10]};
      step();
      chk("R3/R4 ch0 out", 32'(filt_out[0]), 32'(TBL[k][9]));
      chk("R7 ch0 bad", 32'(stat_bad[0]), 32'(TBL[k][8]));
      chk("R5 ch0 elapsed", el(0), 32'(TBL[k][7:0]));
    end

    // fresh start for directed tests
    cond_in = '0; rd_err = '0;
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    chk("R1 re-reset out", 32'(filt_out), 0);

    // R2: tick low, inputs change, nothing moves
    tick = 1'b0; cond_in = '1; rd_err = 4'b0100;
    step(); step();
    chk("R2 out", 32'(filt_out), 0);
    chk("R2 bad", 32'(stat_bad), 0);
    chk("R2 elapsed", 32'(elapsed), 0);
    tick = 1'b1; cond_in = '0; rd_err = '0;

    // R4 / R6: channel 1, on=0, off=3
    cond_in = 4'b0010; step();
    chk("R3 ch1 rise on0", 32'(filt_out[1]), 1);
    chk("R6 ch1 elapsed clear on rise", el(1), 0);
    cond_in = 4'b0000; step(); step(); step();
    chk("R4 ch1 holds after 3 lows", 32'(filt_out[1]), 1);
    chk("R6 ch1 elapsed counts lows", el(1), 3);
    step();
    chk("R4 ch1 drops on 4th low", 32'(filt_out[1]), 0);
    chk("R6 ch1 elapsed 4", el(1), 4);
    cond_in = 4'b0010; step();
    cond_in = 4'b0000; step(); step();
    chk("R6 ch1 elapsed 2", el(1), 2);
    cond_in = 4'b0010; step();
    chk("R6 ch1 elapsed holds on high", el(1), 2);
    cond_in = 4'b0000; step(); step(); step();
    chk("R4 ch1 restart keeps 1", 32'(filt_out[1]), 1);
    chk("R6 ch1 elapsed restarted", el(1), 3);
    step();
    chk("R4 ch1 drops", 32'(filt_out[1]), 0);

    // R7: ch2 force1, ch3 hold
    cond_in = 4'b1000; step();
    chk("R3 ch3 rise", 32'(filt_out[3]), 1);
    cond_in = 4'b0000; rd_err = 4'b1100; step();
    chk("R7 ch2 forced 1", 32'(filt_out[2]), 1);
    chk("R7 ch3 held 1", 32'(filt_out[3]), 1);
    chk("R7 ch2/ch3 bad", 32'(stat_bad), 32'b1100);

    // R8: abort freeze
    abort_mode = 1'b1; rd_err = 4'b0100; step();
    chk("R8 frozen out", 32'(filt_out), 32'b1100);
    chk("R8 frozen bad", 32'(stat_bad), 32'b1100);
    abort_mode = 1'b0; rd_err = 4'b0000; step();
    chk("R8 released out", 32'(filt_out), 0);
    chk("R7 bad clears", 32'(stat_bad), 0);

    // R9: saturation on channel 0 (off=0, input held high)
    cond_in = 4'b0001;
    repeat (65600) @(posedge clk);
    @(negedge clk);
    chk("R9 elapsed saturates", el(0), 32'hFFFF);
    chk("R3 ch0 high", 32'(filt_out[0]), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule